// File: doc/BRIEF.md
# Instruction Mix Counter

This block watches the stream of retired instruction words and keeps one count for each instruction category it sees. Each valid instruction is classified by looking up a small programmable table, indexed by two opcode fields of the instruction word. Each table entry holds a category code, and the counter for that category advances by one. There are five categories: memory access (load/store), floating point, control transfer, integer arithmetic/logic, and a catch-all "other" bucket.

The table is writable and readable through a simple register port, so software can move opcodes between categories while the block is counting. A global enable pauses counting. A synchronous clear zeroes every counter. A select input steers any one counter onto a read port. Counters stop at their maximum value instead of wrapping, so a long run never shows a small, misleading count.

Top module: `imix_counter`

## Requirements
- R1: After reset every counter reads 0 and every table entry reads 4 (other).
- R2: The table index is {insn_word[31:30], insn_word[24:19]}, 8 bits wide. No other bit of the instruction word affects classification.
- R3: On each clock edge where insn_valid=1, count_en=1 and clear=0, exactly one counter increments by one. It is the counter whose number equals the table entry at the index. Category codes are 0 load/store, 1 floating point, 2 control flow, 3 integer ALU, 4 other.
- R4: A table entry of 5, 6 or 7 increments counter 4 (other).
- R5: When count_en=0 or insn_valid=0 on an edge (and clear=0), no counter changes.
- R6: clear=1 sets every counter to 0 on the next edge. An instruction presented in the same cycle is not counted.
- R7: A counter at its maximum value (all ones) stays at that value when its category is hit again.
- R8: A table write (tbl_we=1) updates the entry at tbl_addr on the edge. tbl_rdata shows the new value from the next cycle. An instruction in the same cycle as the write uses the old entry, and later instructions use the new one.
- R9: rd_count returns counter rd_sel for rd_sel 0..4, and 0 for rd_sel 5..7. The read is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Executed instruction word |
| count_en | input | 1 | Counting enable |
| clear | input | 1 | Zero all counters |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Table write index |
| tbl_wdata | input | 3 | Table write category code |
| tbl_raddr | input | 8 | Table read index |
| tbl_rdata | output | 3 | Table entry at tbl_raddr |
| rd_sel | input | 3 | Counter select for readout |
| rd_count | output | CNT_W | Selected counter value |

## Verification
A wrong table entry or a wrong index slice shows up as a count in the wrong category. This is visible on rd_count one edge after the instruction. A stuck, duplicated or skipped increment makes a counter total diverge from the reference in that same cycle. A wrap instead of saturation drops a counter to zero on the first extra hit. The reference model is compared with all counters and one table entry after every edge, so each such fault is reported within one clock of its cause.

// File: rtl/imix_pkg.sv
package imix_pkg;
    localparam int unsigned NUM_CAT = 5;
    localparam int unsigned CAT_W   = 3;

    typedef enum logic [CAT_W-1:0] {
        CAT_LDST  = 3'd0,
        CAT_FP    = 3'd1,
        CAT_CTRL  = 3'd2,
        CAT_ALU   = 3'd3,
        CAT_OTHER = 3'd4
    } imix_cat_e;
endpackage

// File: rtl/imix_opc_table.sv
module imix_opc_table
    import imix_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CAT_W-1:0] wr_code,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [CAT_W-1:0] lk_code,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CAT_W-1:0] rd_code
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][CAT_W-1:0] ent;
    } tbl_st_t;

    tbl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx] = wr_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q.ent[i] <= CAT_OTHER;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // lookup sees registered contents: a same-cycle write is not visible yet
    assign lk_code = st_q.ent[lk_idx];
    assign rd_code = st_q.ent[rd_idx];

    // R8: a write lands at its index on the edge
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.ent[$past(wr_idx)] == $past(wr_code));
endmodule

// File: rtl/imix_classifier.sv
module imix_classifier
    import imix_pkg::*;
(
    input  logic               fire,
    input  logic [CAT_W-1:0]   code,
    output logic [NUM_CAT-1:0] inc_vec
);
    logic [CAT_W-1:0] cat;

    // codes beyond the last category fold into the catch-all bucket
    always_comb begin
        if (code >= CAT_W'(NUM_CAT)) begin
            cat = CAT_W'(NUM_CAT - 1);
        end else begin
            cat = code;
        end
    end

    for (genvar g = 0; g < NUM_CAT; g++) begin : g_hit
        assign inc_vec[g] = fire && (cat == CAT_W'(g));
    end
endmodule

// File: rtl/imix_cat_counter.sv
module imix_cat_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt == CNT_MAX) |=> cnt == CNT_MAX);
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/imix_counter.sv
module imix_counter
    import imix_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned INSN_W  = 32,
    parameter int unsigned MAJ_LSB = 30,
    parameter int unsigned MAJ_W   = 2,
    parameter int unsigned MIN_LSB = 19,
    parameter int unsigned MIN_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       insn_valid,
    input  logic [INSN_W-1:0]          insn_word,
    input  logic                       count_en,
    input  logic                       clear,
    input  logic                       tbl_we,
    input  logic [MAJ_W+MIN_W-1:0]     tbl_addr,
    input  logic [CAT_W-1:0]           tbl_wdata,
    input  logic [MAJ_W+MIN_W-1:0]     tbl_raddr,
    output logic [CAT_W-1:0]           tbl_rdata,
    input  logic [$clog2(NUM_CAT)-1:0] rd_sel,
    output logic [CNT_W-1:0]           rd_count
);
    localparam int unsigned IDX_W = MAJ_W + MIN_W;
    localparam int unsigned SEL_W = $clog2(NUM_CAT);

    logic [IDX_W-1:0]              lk_idx;
    logic [CAT_W-1:0]              lk_code;
    logic                          fire;
    logic [NUM_CAT-1:0]            inc_vec;
    logic [NUM_CAT-1:0][CNT_W-1:0] cnt;

    assign lk_idx = {insn_word[MAJ_LSB +: MAJ_W], insn_word[MIN_LSB +: MIN_W]};
    assign fire   = insn_valid && count_en && !clear;

    imix_opc_table #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_addr),
        .wr_code (tbl_wdata),
        .lk_idx  (lk_idx),
        .lk_code (lk_code),
        .rd_idx  (tbl_raddr),
        .rd_code (tbl_rdata)
    );

    imix_classifier u_class (
        .fire    (fire),
        .code    (lk_code),
        .inc_vec (inc_vec)
    );

    for (genvar g = 0; g < NUM_CAT; g++) begin : g_cnt
        imix_cat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clear),
            .inc   (inc_vec[g]),
            .cnt   (cnt[g])
        );
    end

    always_comb begin
        rd_count = '0;
        for (int k = 0; k < NUM_CAT; k++) begin
            if (rd_sel == SEL_W'(k)) begin
                rd_count = cnt[k];
            end
        end
    end

    // R4: out-of-range table codes must land in the catch-all counter
    p_fold_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && lk_code >= CAT_W'(NUM_CAT)) |-> inc_vec[NUM_CAT-1]);
    // R3: a counted instruction raises exactly one increment
    p_one_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $countones(inc_vec) == 1);
endmodule

// File: tb/imix_counter_tb.sv
`timescale 1ns/1ps
module imix_counter_tb;
    localparam int CLK_PERIOD = 20;
    localparam int CW         = 4;
    localparam int CMAX       = (1 << CW) - 1;
    localparam int WDOG       = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          insn_valid = 1'b0;
    logic [31:0]   insn_word = '0;
    logic          count_en = 1'b0;
    logic          clear = 1'b0;
    logic          tbl_we = 1'b0;
    logic [7:0]    tbl_addr = '0;
    logic [2:0]    tbl_wdata = '0;
    logic [7:0]    tbl_raddr = '0;
    logic [2:0]    tbl_rdata;
    logic [2:0]    rd_sel = '0;
    logic [CW-1:0] rd_count;

    int n_checks = 0;
    int n_fail   = 0;
    int ref_cnt [5];
    int ref_tbl [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    imix_counter #(.CNT_W(CW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_valid (insn_valid),
        .insn_word  (insn_word),
        .count_en   (count_en),
        .clear      (clear),
        .tbl_we     (tbl_we),
        .tbl_addr   (tbl_addr),
        .tbl_wdata  (tbl_wdata),
        .tbl_raddr  (tbl_raddr),
        .tbl_rdata  (tbl_rdata),
        .rd_sel     (rd_sel),
        .rd_count   (rd_count)
    );

    function automatic logic [31:0] mkword(input logic [7:0] idx, input logic [31:0] junk);
        logic [31:0] w;
        w = junk;
        w[31:30] = idx[7:6];
        w[24:19] = idx[5:0];
        return w;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag, input logic [7:0] probe);
        for (int k = 0; k < 8; k++) begin
            rd_sel = k[2:0];
            #1;
            if (k < 5) check(tag, int'(rd_count), ref_cnt[k]);
            else       check("R9", int'(rd_count), 0);
        end
        tbl_raddr = probe;
        #0.5;
        check({tag, " table"}, int'(tbl_rdata), ref_tbl[probe]);
    endtask

    // one clock: drive, update model at the edge, compare at the falling edge
    task automatic cyc(input string tag, input logic v, input logic [31:0] w,
                       input logic en, input logic clr, input logic we,
                       input logic [7:0] wa, input logic [2:0] wd, input logic [7:0] probe);
        int c;
        insn_valid = v; insn_word = w; count_en = en; clear = clr;
        tbl_we = we; tbl_addr = wa; tbl_wdata = wd;
        @(posedge clk);
        if (clr) begin
            for (int k = 0; k < 5; k++) ref_cnt[k] = 0;
        end else if (v && en) begin
            c = ref_tbl[{w[31:30], w[24:19]}];
            if (c > 4) c = 4;
            if (ref_cnt[c] < CMAX) ref_cnt[c]++;
        end
        if (we) ref_tbl[wa] = int'(wd);
        @(negedge clk);
        compare(tag, probe);
    endtask

    task automatic wr(input logic [7:0] a, input logic [2:0] d);
        cyc("R8", 1'b0, '0, 1'b0, 1'b0, 1'b1, a, d, a);
    endtask

    task automatic ins(input string tag, input logic [7:0] idx, input logic [31:0] junk);
        cyc(tag, 1'b1, mkword(idx, junk), 1'b1, 1'b0, 1'b0, 8'd0, 3'd0, idx);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 5; k++) ref_cnt[k] = 0;
        for (int a = 0; a < 256; a++) ref_tbl[a] = 4;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        compare("R1", 8'd0);
        for (int a = 0; a < 256; a += 51) begin
            tbl_raddr = a[7:0];
            #0.2;
            check("R1 table", int'(tbl_rdata), 4);
        end
        // program categories
        wr(8'h00, 3'd0); wr(8'h41, 3'd1); wr(8'h82, 3'd2); wr(8'hC3, 3'd3);
        wr(8'hFF, 3'd5); wr(8'h7E, 3'd6); wr(8'h3D, 3'd7);
        // R3 / R2: each category, with varied unused bits
        ins("R3", 8'h00, 32'h0000_0000);
        ins("R3", 8'h41, 32'h0007_FFFF);
        ins("R3", 8'h82, 32'h3E07_1234);
        ins("R3", 8'hC3, 32'h0000_0000);
        ins("R2", 8'h41, 32'hFFFF_FFFF);
        ins("R2", 8'h82, 32'h3E07_FFFF);
        ins("R3", 8'h55, 32'h1234_5678);
        // R4: codes 5..7 go to other
        ins("R4", 8'hFF, 32'h0);
        ins("R4", 8'h7E, 32'h0);
        ins("R4", 8'h3D, 32'h0);
        // R5: disabled or invalid
        cyc("R5", 1'b1, mkword(8'h00, 0), 1'b0, 1'b0, 1'b0, 8'd0, 3'd0, 8'h00);
        cyc("R5", 1'b0, mkword(8'h41, 0), 1'b1, 1'b0, 1'b0, 8'd0, 3'd0, 8'h41);
        // R8: write and instruction on the same index in one cycle
        cyc("R8", 1'b1, mkword(8'h82, 0), 1'b1, 1'b0, 1'b1, 8'h82, 3'd1, 8'h82);
        ins("R8", 8'h82, 32'h0);
        // R6: clear wins over a same-cycle instruction
        cyc("R6", 1'b1, mkword(8'h00, 0), 1'b1, 1'b1, 1'b0, 8'd0, 3'd0, 8'h00);
        ins("R6", 8'hC3, 32'h0);
        // R7: saturation of the ALU counter
        for (int i = 0; i < CMAX + 4; i++) ins("R7", 8'hC3, 32'h0);
        ins("R3", 8'h00, 32'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule